// File: doc/BRIEF.md
# Configurable HDLC Frame Check Sequence Engine

This block computes the frame check sequence of an HDLC-style link. It absorbs one byte per clock, most significant bit first, through an unrolled eight-step shift. The same module serves the transmit path and the receive path. Three configuration inputs pick the CRC width (16 or 32 bits), the seed (all ones or all zeros) and whether the reported CRC is inverted. The width and the seed are sampled only when a start-of-frame strobe arrives.

On the transmit side, a single pulse on `emit_req` takes a snapshot of the current CRC. The snapshot then leaves the block as 2 or 4 bytes, most significant byte first, on a valid/ready handshake, so it can be appended to the frame. On the receive side, the engine runs over the payload and the received FCS bytes together. It raises `frame_good` when the raw register holds the residue expected for the selected width and inversion mode.

Top module: `hdlc_fcs_engine`

## Requirements
- R1: On `sof`, the register loads all ones (0xFFFF for 16 bits, 0xFFFF_FFFF for 32 bits) when `cfg_zero_seed`=0, and all zeros when it is 1.
- R2: With `cfg_wide`=0 the generator is 0x1021 and `crc_value[31:16]` reads zero. Seed all ones over ASCII "123456789" gives 0x29B1, and seed zero gives 0x31C3.
- R3: With `cfg_wide`=1 the generator is 0x04C1_1DB7. Seed all ones over "123456789" gives 0x0376_E6E7.
- R4: `cfg_invert`=1 presents the bitwise complement of the register across the active width. "123456789" then gives 0xD64E (16-bit, seed ones) and 0xFC89_1918 (32-bit, seed ones).
- R5: `frame_good` is 1 exactly when the raw register equals the residue: 0x1D0F (16-bit) or 0xC704_DD7B (32-bit) when `cfg_invert`=1, and zero when `cfg_invert`=0. Feeding a frame followed by its emitted FCS sets it, and a corrupted byte clears it.
- R6: When `sof` and `din_valid` are high in the same cycle, the byte is dropped and the register holds the seed.
- R7: Changes to `cfg_wide` or `cfg_zero_seed` after `sof` have no effect on the frame in progress.
- R8: After `emit_req`, the snapshot leaves as 2 bytes (16-bit) or 4 bytes (32-bit), most significant byte first, with `out_last` high on the final byte only.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` stays high and `out_data` is held.
- R10: After reset, `crc_value` reads 0x0000_FFFF with `cfg_invert`=0, and `out_valid` and `frame_good` are 0.
- R11: Bytes absorbed during emission do not change the bytes being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 0: 16-bit CRC, 1: 32-bit CRC (sampled at sof) |
| cfg_zero_seed | input | 1 | 0: seed all ones, 1: seed zero (sampled at sof) |
| cfg_invert | input | 1 | Invert reported CRC and select nonzero residue |
| sof | input | 1 | Start-of-frame: reload seed |
| din_valid | input | 1 | Absorb `din` this cycle |
| din | input | 8 | Data byte, MSB first |
| emit_req | input | 1 | Snapshot CRC and start emitting it |
| out_ready | input | 1 | Downstream accepts `out_data` |
| out_valid | output | 1 | Emitted byte valid |
| out_data | output | 8 | Emitted FCS byte |
| out_last | output | 1 | Final FCS byte |
| crc_value | output | 32 | Current CRC, inverted if selected, zero-extended in 16-bit mode |
| frame_good | output | 1 | Residue matches expected check value |

## Verification
The bench runs the standard nine-digit check string through every width, seed and inversion combination. A wrong generator, a seed loaded at the wrong width, or inversion applied to the register rather than to its view would each give a wrong check word. Each emitted FCS is fed back after its payload. A design that emits bytes least significant first, or that compares the inverted view rather than the raw residue, would then fail to flag a good frame. Further tests target the dropped byte in the same cycle as `sof`, configuration flips partway through a frame (an engine that reads the inputs live would switch polynomial in the middle of the frame), stalls on `out_ready`, and data arriving during emission (a design without a snapshot would emit a mix of two CRCs).

// File: rtl/hdlc_fcs_engine.sv
module hdlc_fcs_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wide,
  input  logic        cfg_zero_seed,
  input  logic        cfg_invert,
  input  logic        sof,
  input  logic        din_valid,
  input  logic [7:0]  din,
  input  logic        emit_req,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic [31:0] crc_value,
  output logic        frame_good
);
  localparam logic [15:0] GEN16 = 16'h1021;
  localparam logic [31:0] GEN32 = 32'h04C1_1DB7;
  localparam logic [15:0] RES16 = 16'h1D0F;
  localparam logic [31:0] RES32 = 32'hC704_DD7B;

  logic [31:0] crc_q;
  logic        wide_q;
  logic [31:0] hold_q;
  logic        hold_wide_q;
  logic [1:0]  left_q;
  logic        busy_q;

  function automatic logic [31:0] absorb(input logic [31:0] c, input logic [7:0] d, input logic w);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = (w ? r[31] : r[15]) ^ d[i];
      if (w) r = {r[30:0], 1'b0} ^ (fb ? GEN32 : 32'h0);
      else   r = {16'h0, r[14:0], 1'b0} ^ {16'h0, (fb ? GEN16 : 16'h0)};
    end
    return r;
  endfunction

  wire [31:0] seed = cfg_zero_seed ? 32'h0 : (cfg_wide ? 32'hFFFF_FFFF : 32'h0000_FFFF);
  wire [31:0] mask = cfg_invert ? (wide_q ? 32'hFFFF_FFFF : 32'h0000_FFFF) : 32'h0;

  assign crc_value  = crc_q ^ mask;
  assign frame_good = wide_q ? (crc_q == (cfg_invert ? RES32 : 32'h0))
                             : (crc_q[15:0] == (cfg_invert ? RES16 : 16'h0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= 32'h0000_FFFF;
      wide_q <= 1'b0;
    end else if (sof) begin
      crc_q  <= seed;
      wide_q <= cfg_wide;
    end else if (din_valid) begin
      crc_q  <= absorb(crc_q, din, wide_q);
    end
  end

  wire beat = busy_q && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      hold_q      <= 32'h0;
      hold_wide_q <= 1'b0;
      left_q      <= 2'd0;
    end else if (!busy_q && emit_req) begin
      busy_q      <= 1'b1;
      hold_q      <= crc_value;
      hold_wide_q <= wide_q;
      left_q      <= wide_q ? 2'd3 : 2'd1;
    end else if (beat) begin
      hold_q <= {hold_q[23:0], 8'h0};
      left_q <= left_q - 2'd1;
      if (left_q == 2'd0) busy_q <= 1'b0;
    end
  end

  assign out_valid = busy_q;
  assign out_data  = hold_wide_q ? hold_q[31:24] : hold_q[15:8];
  assign out_last  = busy_q && (left_q == 2'd0);
endmodule

// File: rtl/hdlc_fcs_engine_chk.sv
module hdlc_fcs_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wide,
  input logic        cfg_zero_seed,
  input logic        cfg_invert,
  input logic        sof,
  input logic        din_valid,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_last,
  input logic [31:0] crc_value,
  input logic        frame_good,
  input logic [31:0] crc_q,
  input logic        wide_q
);
  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> crc_q == ($past(cfg_zero_seed) ? 32'h0 : ($past(cfg_wide) ? 32'hFFFF_FFFF : 32'h0000_FFFF))); // R1
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> crc_value[31:16] == 16'h0); // R2
  AST_GOOD_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_good && !cfg_invert) |-> crc_value == 32'h0); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && !din_valid) |=> $stable(crc_q) && $stable(wide_q)); // R7
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last)); // R9
endmodule

bind hdlc_fcs_engine hdlc_fcs_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_zero_seed(cfg_zero_seed),
  .cfg_invert(cfg_invert), .sof(sof), .din_valid(din_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .crc_value(crc_value), .frame_good(frame_good), .crc_q(crc_q), .wide_q(wide_q)
);

// File: tb/sim_hdlc_fcs_engine.sv
module sim_hdlc_fcs_engine;
  logic clk = 0, rst_n = 0;
  logic cfg_wide = 0, cfg_zero_seed = 0, cfg_invert = 0;
  logic sof = 0, din_valid = 0, emit_req = 0, out_ready = 1;
  logic [7:0] din = 0;
  logic out_valid, out_last, frame_good;
  logic [7:0] out_data;
  logic [31:0] crc_value;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  hdlc_fcs_engine u0 (.*);

  localparam logic [7:0] MSG [0:8] = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39};
  // {wide, zero_seed, invert, expected crc_value}
  localparam logic [34:0] VEC [0:4] = '{
    {1'b0,1'b0,1'b0,32'h0000_29B1},
    {1'b0,1'b1,1'b0,32'h0000_31C3},
    {1'b0,1'b0,1'b1,32'h0000_D64E},
    {1'b1,1'b0,1'b0,32'h0376_E6E7},
    {1'b1,1'b0,1'b1,32'hFC89_1918}};

  logic [7:0] got [0:3];
  int nbytes;
  logic last_ok;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_frame();
    sof = 1; @(negedge clk); sof = 0;
  endtask

  task automatic feed(input logic [7:0] b);
    din = b; din_valid = 1; @(negedge clk); din_valid = 0;
  endtask

  task automatic feed_msg();
    for (int i = 0; i < 9; i++) feed(MSG[i]);
  endtask

  task automatic collect();
    nbytes = 0; last_ok = 1;
    emit_req = 1; @(negedge clk); emit_req = 0;
    for (int k = 0; k < 6 && out_valid; k++) begin
      got[nbytes[1:0]] = out_data;
      if (out_last != (nbytes == (cfg_wide ? 3 : 1))) last_ok = 0;
      nbytes++;
      @(negedge clk);
    end
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    repeat (2) @(negedge clk);
    chk(crc_value == 32'h0000_FFFF, "R10 reset crc", crc_value, 32'h0000_FFFF);
    chk(!out_valid && !frame_good, "R10 reset flags", {out_valid, frame_good}, 0);
    rst_n = 1; @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      logic [31:0] exp;
      exp = VEC[v][31:0];
      {cfg_wide, cfg_zero_seed, cfg_invert} = VEC[v][34:32];
      start_frame();
      feed_msg();
      chk(crc_value == exp, cfg_wide ? (cfg_invert ? "R4 R3 check" : "R3 check")
                                     : (cfg_invert ? "R4 R2 check" : "R2 R1 check"), crc_value, exp);
      collect();
      chk(nbytes == (cfg_wide ? 4 : 2) && last_ok, "R8 byte count/last", nbytes, cfg_wide ? 4 : 2);
      if (cfg_wide)
        chk({got[0],got[1],got[2],got[3]} == exp, "R8 order", {got[0],got[1],got[2],got[3]}, exp);
      else
        chk({got[0],got[1]} == exp[15:0], "R8 order", {got[0],got[1]}, exp[15:0]);
      start_frame();
      feed_msg();
      for (int j = 0; j < nbytes; j++) feed(got[j]);
      chk(frame_good, "R5 residue good", crc_value, 0);
      start_frame();
      feed(8'h30);
      for (int i = 1; i < 9; i++) feed(MSG[i]);
      for (int j = 0; j < nbytes; j++) feed(got[j]);
      chk(!frame_good, "R5 corrupted frame", frame_good, 0);
    end

    // R6: byte alongside sof dropped
    {cfg_wide, cfg_zero_seed, cfg_invert} = 3'b000;
    din = 8'hA5; din_valid = 1; sof = 1; @(negedge clk); sof = 0; din_valid = 0;
    chk(crc_value == 32'h0000_FFFF, "R6 sof priority", crc_value, 32'h0000_FFFF);
    feed_msg();
    chk(crc_value == 32'h0000_29B1, "R6 after dropped byte", crc_value, 32'h29B1);

    // R1: zero seed 32-bit
    {cfg_wide, cfg_zero_seed, cfg_invert} = 3'b110;
    start_frame();
    chk(crc_value == 32'h0, "R1 zero seed 32", crc_value, 0);

    // R7: config flip mid-frame
    {cfg_wide, cfg_zero_seed, cfg_invert} = 3'b000;
    start_frame();
    for (int i = 0; i < 4; i++) feed(MSG[i]);
    cfg_wide = 1; cfg_zero_seed = 1;
    for (int i = 4; i < 9; i++) feed(MSG[i]);
    chk(crc_value == 32'h0000_29B1, "R7 mid-frame config", crc_value, 32'h29B1);

    // R9: stall
    out_ready = 0;
    emit_req = 1; @(negedge clk); emit_req = 0;
    begin
      logic [7:0] first;
      first = out_data;
      chk(out_valid && first == 8'h29, "R9 first byte", first, 8'h29);
      repeat (3) @(negedge clk);
      chk(out_valid && out_data == first && !out_last, "R9 held", out_data, first);
    end
    // R11: data during emission
    feed(8'hFF);
    out_ready = 1;
    chk(out_valid && out_data == 8'h29, "R11 byte0 kept", out_data, 8'h29);
    @(negedge clk);
    chk(out_valid && out_data == 8'hB1 && out_last, "R11 byte1 kept", out_data, 8'hB1);
    @(negedge clk);
    chk(!out_valid, "R8 done", out_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule